// File: doc/BRIEF.md
# Low-Power Clock Enable Controller

This block derives three clock domains (a main processor clock, a sub-system clock and an auxiliary clock) from a fast oscillator and an optional slow oscillator. It works entirely in the fast oscillator's domain. The slow oscillator reaches it as a synchronized one-cycle tick, and each derived clock leaves it as a one-cycle enable pulse that drives a clock-gate cell outside the block. Each derived clock has a power-of-two divider. The main and sub-system clocks can each pick their source, and switching between sources never yields a partial pulse.

Four low-power inputs from the processor status word control the gating. The first stops the main clock, and a pending interrupt wake-up overrides it. The second lets the fast oscillator shut down. The third stops the sub-system clock. The fourth lets the slow oscillator shut down. An oscillator is only released when no running clock still depends on it. Two byte-wide registers on a simple peripheral bus set the dividers and sources. The parameter `HAS_SLOW` removes the slow domain completely, and the fast oscillator then drives every clock.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset both registers read 0x00. The main and sub-system enables pulse on every fast cycle, and the auxiliary enable pulses on every slow tick.
- R2: Register address 1 holds the main source in bit 7 (1 = slow), the main divider code in bits 5:4, the sub-system source in bit 3 and the sub-system divider code in bits 2:1. Register address 0 holds the auxiliary divider code in bits 5:4. All other bits read 0, and data reads back only while selected with write low.
- R3: A divider code n gives one enable pulse per 2^n ticks of the selected source, for n in 0..3, on all three clocks. The auxiliary clock always counts slow ticks.
- R4: A new divider code takes effect only at the end of the current divide period. The first pulse after a write comes within the old ratio, and every later interval equals the new ratio.
- R5: After a source select changes, no pulse is produced in the following cycle or until two ticks of the new source have elapsed after it. Pulses then coincide with ticks of the new source. With the fast source, the first pulse arrives in the fourth cycle after the write edge.
- R6: With the CPU-off input high and no wake-up, the main enable stops from the next cycle on, while the sub-system enable keeps running. A wake-up restores the main enable within two fast cycles.
- R7: With the sub-system-off input high, the sub-system enable stops from the next cycle on, while the main enable keeps running.
- R8: The fast oscillator enable is low only when the fast-off input is high and neither the running main clock nor the running sub-system clock selects the fast source.
- R9: The slow oscillator enable is low only when the slow-off input is high and no running main or sub-system clock selects the slow source. The auxiliary enable stays low from the cycle after the slow oscillator is released.
- R10: With `HAS_SLOW` = 0, bits 7 and 3 of register 1 read 0 and have no effect, the main clock stays on the fast source, and the slow oscillator enable is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock, the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow oscillator period, already synchronized |
| lpm_cpuoff | input | 1 | Low-power bit: stop the main clock |
| lpm_fastoff | input | 1 | Low-power bit: allow the fast oscillator to stop |
| lpm_suboff | input | 1 | Low-power bit: stop the sub-system clock |
| lpm_slowoff | input | 1 | Low-power bit: allow the slow oscillator to stop |
| irq_wake | input | 1 | Interrupt wake-up, overrides the CPU-off bit |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 1 | Register select: 0 auxiliary, 1 main/sub-system |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| mclk_en | output | 1 | Main clock enable pulse |
| smclk_en | output | 1 | Sub-system clock enable pulse |
| aclk_en | output | 1 | Auxiliary clock enable pulse |
| fast_osc_en | output | 1 | Keep the fast oscillator running |
| slow_osc_en | output | 1 | Keep the slow oscillator running |

## Verification
A divider counter holding a wrong value or an active ratio latched at the wrong time shows on the pulse train. The first interval after a write would have the wrong length, so an interval sweep over every old/new ratio pair exposes it within eight source ticks. A selector that leaves its hold state early or late changes the count of silent cycles after a source write, which is checked to the cycle on the fast source and to within one tick on the slow source. A wrong gate register or oscillator-release term shows in the cycle after a low-power input changes. An exhaustive sweep of all low-power and source combinations catches it at once.

// File: rtl/lpclk_pkg.sv
`timescale 1ns/1ps
package lpclk_pkg;

   // divider code width fixed by the register layout
   localparam int DIVSEL_W = 2;

   // field positions decoded by software
   localparam int MAIN_SRC_BIT = 7;
   localparam int MAIN_DIV_LO  = 4;
   localparam int SUB_SRC_BIT  = 3;
   localparam int SUB_DIV_LO   = 1;
   localparam int AUX_DIV_LO   = 4;

   typedef enum logic {
      SRC_FAST = 1'b0,
      SRC_SLOW = 1'b1
   } clk_src_e;

   typedef struct packed {
      clk_src_e              msrc;
      logic [DIVSEL_W-1:0]   mdiv;
      clk_src_e              ssrc;
      logic [DIVSEL_W-1:0]   sdiv;
      logic [DIVSEL_W-1:0]   adiv;
   } clk_cfg_t;

endpackage

// File: rtl/lpclk_regs.sv
`timescale 1ns/1ps
module lpclk_regs
   import lpclk_pkg::*;
#(
   parameter bit HAS_SLOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_we,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output clk_cfg_t   cfg_o
);

   logic [DIVSEL_W-1:0] adiv_q, mdiv_q, sdiv_q;
   clk_src_e            msrc_q, ssrc_q;
   logic                wr_aux, wr_main;
   logic                unused_wbits;

   assign wr_aux       = bus_sel && bus_we && !bus_addr;
   assign wr_main      = bus_sel && bus_we &&  bus_addr;
   assign unused_wbits = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adiv_q <= '0;
         mdiv_q <= '0;
         sdiv_q <= '0;
      end else begin
         if (wr_aux) adiv_q <= bus_wdata[AUX_DIV_LO +: DIVSEL_W];
         if (wr_main) begin
            mdiv_q <= bus_wdata[MAIN_DIV_LO +: DIVSEL_W];
            sdiv_q <= bus_wdata[SUB_DIV_LO  +: DIVSEL_W];
         end
      end
   end

   generate
      if (HAS_SLOW) begin : g_src_regs
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               msrc_q <= SRC_FAST;
               ssrc_q <= SRC_FAST;
            end else if (wr_main) begin
               msrc_q <= clk_src_e'(bus_wdata[MAIN_SRC_BIT]);
               ssrc_q <= clk_src_e'(bus_wdata[SUB_SRC_BIT]);
            end
         end
      end else begin : g_src_tied
         assign msrc_q = SRC_FAST;
         assign ssrc_q = SRC_FAST;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_we) begin
         if (!bus_addr) begin
            bus_rdata[AUX_DIV_LO +: DIVSEL_W] = adiv_q;
         end else begin
            bus_rdata[MAIN_SRC_BIT]              = (msrc_q == SRC_SLOW);
            bus_rdata[MAIN_DIV_LO +: DIVSEL_W]   = mdiv_q;
            bus_rdata[SUB_SRC_BIT]               = (ssrc_q == SRC_SLOW);
            bus_rdata[SUB_DIV_LO  +: DIVSEL_W]   = sdiv_q;
         end
      end
   end

   assign cfg_o = '{msrc: msrc_q, mdiv: mdiv_q, ssrc: ssrc_q, sdiv: sdiv_q, adiv: adiv_q};

   // R2: a write to the main register is visible on the next read
   a_r2_main_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_main |=> (cfg_o.mdiv == $past(bus_wdata[MAIN_DIV_LO +: DIVSEL_W])));

endmodule

// File: rtl/lpclk_srcsel.sv
`timescale 1ns/1ps
module lpclk_srcsel
   import lpclk_pkg::*;
#(
   parameter int WAIT_TICKS = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fast_tick,
   input  logic     slow_tick,
   input  clk_src_e sel,
   output logic     tick_o
);

   localparam int CW = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;

   typedef enum logic { SW_RUN = 1'b0, SW_HOLD = 1'b1 } sw_state_e;

   sw_state_e       state_q;
   clk_src_e        cur_q;
   logic [CW-1:0]   wait_q;
   logic            cur_tick;

   initial begin
      if (WAIT_TICKS < 1) $error("lpclk_srcsel: WAIT_TICKS must be at least 1");
   end

   assign cur_tick = (cur_q == SRC_SLOW) ? slow_tick : fast_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SW_RUN;
         cur_q   <= SRC_FAST;
         wait_q  <= '0;
      end else if (sel != cur_q) begin
         // old source already silenced; wait on the new one
         cur_q   <= sel;
         state_q <= SW_HOLD;
         wait_q  <= '0;
      end else if (state_q == SW_HOLD && cur_tick) begin
         if (wait_q == CW'(WAIT_TICKS - 1)) state_q <= SW_RUN;
         else                               wait_q  <= wait_q + 1'b1;
      end
   end

   assign tick_o = (state_q == SW_RUN) && (sel == cur_q) && cur_tick;

   // R5: a select change always forces a hold on the next cycle
   a_r5_change_enters_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != cur_q) |=> (state_q == SW_HOLD));

endmodule

// File: rtl/lpclk_div.sv
`timescale 1ns/1ps
module lpclk_div #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             run,
   output logic             pulse_o
);

   localparam int CNT_W = (1 << SEL_W) - 1;

   logic [CNT_W-1:0] cnt_q, term;
   logic [SEL_W-1:0] act_q;

   initial begin
      if (SEL_W < 1 || SEL_W > 3) $error("lpclk_div: SEL_W out of range");
   end

   assign term = CNT_W'((1 << act_q) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (src_tick) begin
         if (cnt_q == term) begin
            cnt_q <= '0;
            act_q <= div_sel;   // ratio only changes on a period boundary
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pulse_o = src_tick && run && (cnt_q == term);

   // R4: the count never runs past the active terminal value
   a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= term);

endmodule

// File: rtl/lpclk_ctrl.sv
`timescale 1ns/1ps
module lpclk_ctrl
   import lpclk_pkg::*;
#(
   parameter bit HAS_SLOW    = 1'b1,
   parameter int DIV_SEL_W   = DIVSEL_W,
   parameter int WAIT_TICKS  = 2
) (
   input  logic       clk_fast,
   input  logic       rst_n,
   input  logic       slow_tick,
   input  logic       lpm_cpuoff,
   input  logic       lpm_fastoff,
   input  logic       lpm_suboff,
   input  logic       lpm_slowoff,
   input  logic       irq_wake,
   input  logic       bus_sel,
   input  logic       bus_we,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       mclk_en,
   output logic       smclk_en,
   output logic       aclk_en,
   output logic       fast_osc_en,
   output logic       slow_osc_en
);

   clk_cfg_t cfg;
   logic     main_need, sub_need;
   logic     mgate_q, sgate_q, agate_q, agate_d;
   logic     m_tick, s_tick, a_tick;

   initial begin
      if (DIV_SEL_W != DIVSEL_W) $error("lpclk_ctrl: divider code width fixed by register layout");
   end

   lpclk_regs #(.HAS_SLOW(HAS_SLOW)) u_regs (
      .clk(clk_fast), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_o(cfg)
   );

   assign main_need = !(lpm_cpuoff && !irq_wake);
   assign sub_need  = !lpm_suboff;

   generate
      if (HAS_SLOW) begin : g_slow
         lpclk_srcsel #(.WAIT_TICKS(WAIT_TICKS)) u_msel (
            .clk(clk_fast), .rst_n(rst_n), .fast_tick(1'b1),
            .slow_tick(slow_tick), .sel(cfg.msrc), .tick_o(m_tick)
         );
         lpclk_srcsel #(.WAIT_TICKS(WAIT_TICKS)) u_ssel (
            .clk(clk_fast), .rst_n(rst_n), .fast_tick(1'b1),
            .slow_tick(slow_tick), .sel(cfg.ssrc), .tick_o(s_tick)
         );
         assign a_tick      = slow_tick;
         assign fast_osc_en = !lpm_fastoff
                            || (main_need && cfg.msrc == SRC_FAST)
                            || (sub_need  && cfg.ssrc == SRC_FAST);
         assign slow_osc_en = !lpm_slowoff
                            || (main_need && cfg.msrc == SRC_SLOW)
                            || (sub_need  && cfg.ssrc == SRC_SLOW);
         assign agate_d     = slow_osc_en;

         // R5: on the slow source a main pulse only comes with a slow tick
         a_r5_slow_pulse_on_tick: assert property (@(posedge clk_fast) disable iff (!rst_n)
            (cfg.msrc == SRC_SLOW && mclk_en) |-> slow_tick);
         // R5: no main pulse in the cycle right after a select change
         a_r5_quiet_after_select: assert property (@(posedge clk_fast) disable iff (!rst_n)
            (cfg.msrc != $past(cfg.msrc)) |-> !mclk_en);
         // R9: auxiliary clock stops once the slow oscillator is released
         a_r9_aclk_needs_osc: assert property (@(posedge clk_fast) disable iff (!rst_n)
            !slow_osc_en |=> !aclk_en);
      end else begin : g_fast_only
         logic unused_slow;
         assign unused_slow = ^{slow_tick, lpm_slowoff, cfg.msrc, cfg.ssrc};
         assign m_tick      = 1'b1;
         assign s_tick      = 1'b1;
         assign a_tick      = 1'b1;
         assign fast_osc_en = !lpm_fastoff || main_need || sub_need;
         assign slow_osc_en = 1'b0;
         assign agate_d     = 1'b1;

         // R10: source bits never read back as set
         a_r10_no_slow_select: assert property (@(posedge clk_fast) disable iff (!rst_n)
            (bus_sel && !bus_we && bus_addr) |-> (!bus_rdata[MAIN_SRC_BIT] && !bus_rdata[SUB_SRC_BIT]));
      end
   endgenerate

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) begin
         mgate_q <= 1'b1;
         sgate_q <= 1'b1;
         agate_q <= 1'b1;
      end else begin
         mgate_q <= main_need;
         sgate_q <= sub_need;
         agate_q <= agate_d;
      end
   end

   lpclk_div #(.SEL_W(DIV_SEL_W)) u_mdiv (
      .clk(clk_fast), .rst_n(rst_n), .src_tick(m_tick),
      .div_sel(cfg.mdiv), .run(mgate_q), .pulse_o(mclk_en)
   );
   lpclk_div #(.SEL_W(DIV_SEL_W)) u_sdiv (
      .clk(clk_fast), .rst_n(rst_n), .src_tick(s_tick),
      .div_sel(cfg.sdiv), .run(sgate_q), .pulse_o(smclk_en)
   );
   lpclk_div #(.SEL_W(DIV_SEL_W)) u_adiv (
      .clk(clk_fast), .rst_n(rst_n), .src_tick(a_tick),
      .div_sel(cfg.adiv), .run(agate_q), .pulse_o(aclk_en)
   );

   // R6: CPU-off without wake-up silences the main clock next cycle
   a_r6_cpuoff_halts_mclk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (lpm_cpuoff && !irq_wake) |=> !mclk_en);
   // R6: a wake-up reopens the main gate on the next cycle
   a_r6_wake_reopens: assert property (@(posedge clk_fast) disable iff (!rst_n)
      irq_wake |=> mgate_q);
   // R7: sub-system-off silences the sub-system clock next cycle
   a_r7_suboff_halts_smclk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      lpm_suboff |=> !smclk_en);

endmodule

// File: tb/lpclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpclk_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lf_tick = 1'b0;
   logic cpuoff = 1'b0, fastoff = 1'b0, suboff = 1'b0, slowoff = 1'b0, wake = 1'b0;
   logic bsel = 1'b0, bwe = 1'b0, baddr = 1'b0;
   logic [7:0] bwd = 8'h00;
   logic [7:0] rdata, rdata_n;
   logic m_en, s_en, a_en, f_osc, s_osc;
   logic m_en_n, s_en_n, a_en_n, f_osc_n, s_osc_n;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   lpclk_ctrl #(.HAS_SLOW(1'b1)) dut_i (
      .clk_fast(clk), .rst_n(rst_n), .slow_tick(lf_tick),
      .lpm_cpuoff(cpuoff), .lpm_fastoff(fastoff), .lpm_suboff(suboff),
      .lpm_slowoff(slowoff), .irq_wake(wake),
      .bus_sel(bsel), .bus_we(bwe), .bus_addr(baddr), .bus_wdata(bwd),
      .bus_rdata(rdata), .mclk_en(m_en), .smclk_en(s_en), .aclk_en(a_en),
      .fast_osc_en(f_osc), .slow_osc_en(s_osc)
   );

   lpclk_ctrl #(.HAS_SLOW(1'b0)) dut_nolf_i (
      .clk_fast(clk), .rst_n(rst_n), .slow_tick(lf_tick),
      .lpm_cpuoff(cpuoff), .lpm_fastoff(fastoff), .lpm_suboff(suboff),
      .lpm_slowoff(slowoff), .irq_wake(wake),
      .bus_sel(bsel), .bus_we(bwe), .bus_addr(baddr), .bus_wdata(bwd),
      .bus_rdata(rdata_n), .mclk_en(m_en_n), .smclk_en(s_en_n), .aclk_en(a_en_n),
      .fast_osc_en(f_osc_n), .slow_osc_en(s_osc_n)
   );

   // slow tick: one fast cycle in three, changed away from both edges
   initial begin
      int ph = 0;
      forever begin
         @(posedge clk); #2;
         ph = (ph + 1) % 3;
         lf_tick = (ph == 0);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bsel = 1'b1; bwe = 1'b1; baddr = a; bwd = d;
      @(posedge clk); #1;
      bsel = 1'b0; bwe = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] v, output logic [7:0] vn);
      @(negedge clk);
      bsel = 1'b1; bwe = 1'b0; baddr = a;
      #1; v = rdata; vn = rdata_n;
      @(posedge clk); #1;
      bsel = 1'b0;
   endtask

   // count pulses of each enable over n cycles
   task automatic count_pulses(input int n, output int cm, output int cs, output int ca);
      cm = 0; cs = 0; ca = 0;
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         cm += int'(m_en); cs += int'(s_en); ca += int'(a_en);
      end
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v, vn;
      int cm, cs, ca;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // ---- R1 reset state
      rd(1'b0, v, vn); chk(v == 8'h00, "R1 aux reg", v, 0);
      rd(1'b1, v, vn); chk(v == 8'h00, "R1 main reg", v, 0);
      count_pulses(24, cm, cs, ca);
      chk(cm == 24, "R1 mclk every cycle", cm, 24);
      chk(cs == 24, "R1 smclk every cycle", cs, 24);
      chk(ca == 8, "R1 aclk per slow tick", ca, 8);

      // ---- R2 layout and read-back
      wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
      rd(1'b0, v, vn); chk(v == 8'h30, "R2 aux read", v, 8'h30);
      rd(1'b1, v, vn); chk(v == 8'hBE, "R2 main read", v, 8'hBE);
      chk(vn == 8'h36, "R10 main read no slow", vn, 8'h36);
      @(negedge clk); #1 chk(rdata == 8'h00, "R2 idle read zero", rdata, 0);
      wr(1'b0, 8'h00); wr(1'b1, 8'h00);
      repeat (30) @(negedge clk);

      // ---- R3 ratio sweep on all three clocks
      for (int n = 0; n < 4; n++) begin
         wr(1'b1, 8'((n << 4) | ((3 - n) << 1)));
         wr(1'b0, 8'(n << 4));
         repeat (40) @(negedge clk);
         count_pulses(96, cm, cs, ca);
         chk(cm == (96 >> n), "R3 mclk ratio", cm, 96 >> n);
         chk(cs == (96 >> (3 - n)), "R3 smclk ratio", cs, 96 >> (3 - n));
         chk(ca == (32 >> n), "R3 aclk ratio", ca, 32 >> n);
      end
      wr(1'b0, 8'h00);

      // ---- R4 ratio change at period boundary, all old/new pairs
      for (int p = 0; p < 16; p++) begin
         int ro, rn, last, first, bad, npul;
         ro = 1 << (p / 4); rn = 1 << (p % 4);
         wr(1'b1, 8'((p / 4) << 4));
         repeat (20 + (p % 8)) @(negedge clk);
         wr(1'b1, 8'((p % 4) << 4));
         last = -1; first = -1; bad = 0; npul = 0;
         for (int c = 0; c < 48; c++) begin
            @(negedge clk);
            if (m_en) begin
               if (first < 0) first = c;
               if (last >= 0 && (c - last) != rn) bad++;
               last = c; npul++;
            end
         end
         chk(first >= 0 && first < ro, "R4 first pulse within old ratio", first, ro);
         chk(bad == 0 && npul >= 3, "R4 intervals equal new ratio", bad, 0);
      end
      wr(1'b1, 8'h00);
      repeat (10) @(negedge clk);

      // ---- R5 switch main to slow source, then back
      begin
         int ticks, quiet, mism, nolf;
         wr(1'b1, 8'h80);
         ticks = 0; quiet = 0;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (m_en) break;
            quiet++; ticks += int'(lf_tick);
         end
         chk(ticks >= 2 && ticks <= 3, "R5 slow hold ticks", ticks, 2);
         mism = 0; nolf = 0;
         for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (m_en != lf_tick) mism++;
            nolf += int'(m_en_n);
         end
         chk(mism == 0, "R5 pulses follow slow ticks", mism, 0);
         chk(nolf == 30, "R10 main stays fast", nolf, 30);
         wr(1'b1, 8'h00);
         quiet = 0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (m_en) break;
            quiet++;
         end
         chk(quiet == 3, "R5 fast hold cycles", quiet, 3);
         repeat (10) @(negedge clk);
      end

      // ---- R6 CPU-off and wake-up
      begin
         int seen, wt;
         @(negedge clk); cpuoff = 1'b1;
         count_pulses(10, cm, cs, ca);
         chk(cm == 0, "R6 mclk stopped", cm, 0);
         chk(cs == 10, "R6 smclk keeps running", cs, 10);
         @(negedge clk); wake = 1'b1;
         seen = 0; wt = 0;
         for (int c = 0; c < 4 && !seen; c++) begin
            @(negedge clk); wt++;
            seen = int'(m_en);
         end
         chk(seen == 1 && wt <= 2, "R6 wake resumes mclk", wt, 2);
         cpuoff = 1'b0; wake = 1'b0;
      end

      // ---- R7 sub-system off
      @(negedge clk); suboff = 1'b1;
      count_pulses(10, cm, cs, ca);
      chk(cs == 0, "R7 smclk stopped", cs, 0);
      chk(cm == 10, "R7 mclk keeps running", cm, 10);
      suboff = 1'b0;
      repeat (3) @(negedge clk);

      // ---- R8 / R9 exhaustive oscillator-release sweep
      for (int sc = 0; sc < 4; sc++) begin
         wr(1'b1, 8'(((sc >> 1) << 7) | ((sc & 1) << 3)));
         for (int lp = 0; lp < 16; lp++) begin
            bit co, fo, so, lo, ms, ss, ef, es, efn;
            co = lp[0]; fo = lp[1]; so = lp[2]; lo = lp[3];
            ms = sc[1]; ss = sc[0];
            @(negedge clk);
            cpuoff = co; fastoff = fo; suboff = so; slowoff = lo;
            #1;
            ef  = !fo || (!co && !ms) || (!so && !ss);
            es  = !lo || (!co &&  ms) || (!so &&  ss);
            efn = !fo || !co || !so;
            chk(f_osc == ef, "R8 fast osc enable", f_osc, ef);
            chk(s_osc == es, "R9 slow osc enable", s_osc, es);
            chk(f_osc_n == efn && s_osc_n == 1'b0, "R10 osc enables no slow", f_osc_n, efn);
         end
      end
      @(negedge clk);
      cpuoff = 1'b0; fastoff = 1'b0; suboff = 1'b0; slowoff = 1'b0;
      wr(1'b1, 8'h00);
      repeat (10) @(negedge clk);

      // ---- R9 auxiliary clock stops with slow oscillator released
      @(negedge clk); slowoff = 1'b1;
      repeat (2) @(negedge clk);
      chk(s_osc == 1'b0, "R9 slow osc released", s_osc, 0);
      count_pulses(30, cm, cs, ca);
      chk(ca == 0, "R9 aclk stopped", ca, 0);
      @(negedge clk); slowoff = 1'b0;
      count_pulses(9, cm, cs, ca);
      chk(ca >= 2, "R9 aclk resumes", ca, 3);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule